// File: doc/BRIEF.md
# Resistive Touch Scan Host Controller

This block is the host-side master for an external four-wire resistive touch converter that has a serial command and result interface. It sits idle until the converter's active-low pen line is pulled low. It then selects the converter and generates the serial clock from the system clock by a fixed divide. It shifts out three command bytes back to back, one every `RES_BITS + 3` serial clocks: a Y reading, an X reading, and a final flush command that lets the converter power down. Each command byte is sent while the result of the previous one is still coming back.

The results come back MSB first and are shifted in on rising serial-clock edges. The block then deselects the converter and waits a programmable number of system clocks before it looks at the pen line, because the line is meaningless while the drive switches are on. If the pen is still down at that point, it presents the X and Y values with a one-cycle strobe. If the pen has gone up, it drops the scan silently. While the pen stays down, scans repeat back to back.

Top module: `tsc_scan_master`

## Requirements
- R1: While reset is asserted, the outputs are as follows: select is high, serial clock low, serial data out low, strobe low, and both coordinates zero.
- R2: With the pen line high, select never falls and no serial clock is produced.
- R3: From idle, once the settle period has expired, a low pen line makes select fall on the third rising system-clock edge after the line goes low.
- R4: Every serial-clock high phase and low phase lasts exactly `DCLK_HALF` system clocks. The first low phase is measured from the fall of select. The serial clock is low whenever select is high.
- R5: One scan contains exactly `3*(RES_BITS+3)` rising serial-clock edges while select is low. The command start bits fall on edges 1, `RES_BITS+4` and `2*RES_BITS+7`.
- R6: Each command byte is sent MSB first, and serial data out changes only while the serial clock is low. The byte layout is: bit 7 = 1 (start), bits 6:4 = channel, bit 3 = 1 for 8-bit resolution, bit 2 = 1 for single-ended reference (0 when `DIFF_REF`=1), bits 1:0 = power code. The three bytes are sent in this order:
  - channel 001 with power 11;
  - channel 101 with power 11;
  - channel 001 with power 00.

  Serial data out is 0 on every edge outside these bytes.
- R7: The Y result is assembled MSB first from the serial input sampled on rising edges 10 to `9+RES_BITS`. The X result comes from edges `RES_BITS+13` to `2*RES_BITS+12`.
- R8: Select rises at the last serial-clock fall. `SETTLE_CYC+1` system clocks later, if the pen line is low, the strobe is high for exactly one cycle, together with the new X and Y values.
- R9: If the pen line is high at that decision point, no strobe is produced and both coordinate outputs keep their previous values.
- R10: Changes on the pen line while select is low have no effect: the running scan neither aborts nor restarts, and its result is still delivered if the pen is down at the end.
- R11: While the pen stays down, a new scan starts right after each strobe, and each scan reports the values converted during that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pen_n | input | 1 | Pen line from the converter, low while touched |
| tsc_dout | input | 1 | Serial result bit from the converter |
| tsc_cs_n | output | 1 | Converter select, active low |
| tsc_dclk | output | 1 | Serial clock to the converter |
| tsc_din | output | 1 | Serial command bit to the converter |
| coord_valid | output | 1 | One-cycle strobe for a new coordinate pair |
| coord_x | output | RES_BITS | Latest X result |
| coord_y | output | RES_BITS | Latest Y result |

## Verification
The bench plays the converter. It finds each command by its start bit, checks the byte contents and edge positions, and returns per-channel values one serial clock after the command's last bit. A framing error of one edge therefore shows up either as a shifted result or as a misplaced start bit. Alternating-bit and all-ones/all-zeros values expose a reversed bit order or a capture window off by one. A pen release timed just after the strobe forces a trailing scan whose end decision must stay silent. A design that latched values anyway would disturb the held outputs. A pen bounce in the middle of a scan catches a design that restarts or aborts when it should mask the line.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } scan_state_t;

  localparam logic [2:0] CH_Y     = 3'b001;
  localparam logic [2:0] CH_X     = 3'b101;
  localparam logic [1:0] PWR_KEEP = 2'b11;
  localparam logic [1:0] PWR_AUTO = 2'b00;

  // start bit, channel, resolution flag, reference flag, power code
  function automatic logic [7:0] make_cmd(input logic [2:0] ch,
                                          input logic       eight_bit,
                                          input logic       single_ref,
                                          input logic [1:0] pwr);
    return {1'b1, ch, eight_bit, single_ref, pwr};
  endfunction

endpackage

// File: rtl/tsc_dclk_gen.sv
`timescale 1ns/1ps
module tsc_dclk_gen #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic dclk,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end   = run && (cnt == CW'(HALF - 1));
  assign rise_now = at_end && !dclk;
  assign fall_now = at_end && dclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      dclk <= 1'b0;
    end else if (at_end) begin
      cnt  <= '0;
      dclk <= ~dclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  assert_half_cnt_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HALF - 1));

  assert_rise_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> $past(run));

endmodule

// File: rtl/tsc_pen_gate.sv
`timescale 1ns/1ps
module tsc_pen_gate #(
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pen_n,
  input  logic hold,
  output logic pen_down,
  output logic armed
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [1:0]    sync;
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], pen_n};
      if (hold)
        cnt <= '0;
      else if (cnt != SW'(SETTLE))
        cnt <= cnt + 1'b1;
    end
  end

  assign pen_down = !sync[1];
  assign armed    = !hold && (cnt == SW'(SETTLE));

  assert_settle_count_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ($past(cnt) == SW'(SETTLE - 1)));

endmodule

// File: rtl/tsc_capture.sv
`timescale 1ns/1ps
module tsc_capture #(
  parameter int RES   = 12,
  parameter int FIRST = 10,
  parameter int EW    = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample,
  input  logic [EW-1:0]  edge_num,
  input  logic           sdi,
  output logic [RES-1:0] value
);
  logic in_win;

  assign in_win = (edge_num >= EW'(FIRST)) && (edge_num < EW'(FIRST + RES));

  always_ff @(posedge clk) begin
    if (rst)
      value <= '0;
    else if (sample && in_win)
      value <= {value[RES-2:0], sdi};
  end

endmodule

// File: rtl/tsc_scan_master.sv
`timescale 1ns/1ps
module tsc_scan_master
  import tsc_pkg::*;
#(
  parameter int DCLK_HALF  = 20,
  parameter int RES_BITS   = 12,
  parameter int DIFF_REF   = 1,
  parameter int SETTLE_CYC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pen_n,
  input  logic                tsc_dout,
  output logic                tsc_cs_n,
  output logic                tsc_dclk,
  output logic                tsc_din,
  output logic                coord_valid,
  output logic [RES_BITS-1:0] coord_x,
  output logic [RES_BITS-1:0] coord_y
);
  localparam int FRAME = RES_BITS + 3;
  localparam int TOTAL = 3 * FRAME;
  localparam int EW    = $clog2(TOTAL + 1);
  localparam int PW    = $clog2(FRAME);

  localparam logic EIGHT   = (RES_BITS == 8);
  localparam logic SGL_REF = (DIFF_REF == 0);
  localparam logic [7:0] CMD_Y   = make_cmd(CH_Y, EIGHT, SGL_REF, PWR_KEEP);
  localparam logic [7:0] CMD_X   = make_cmd(CH_X, EIGHT, SGL_REF, PWR_KEEP);
  localparam logic [7:0] CMD_END = make_cmd(CH_Y, EIGHT, SGL_REF, PWR_AUTO);

  scan_state_t   state;
  logic          run_en;
  logic          rise_now, fall_now;
  logic          pen_down, armed;
  logic [EW-1:0] edge_cnt, edge_nxt;
  logic [PW-1:0] pos;
  logic [1:0]    frm;
  logic [7:0]    cur_cmd;
  logic [2:0]    bidx;
  logic          next_bit;
  logic [RES_BITS-1:0] cap [2];

  assign run_en   = (state == ST_RUN);
  assign edge_nxt = edge_cnt + 1'b1;

  tsc_dclk_gen #(.HALF(DCLK_HALF)) u_dclk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_en),
    .dclk     (tsc_dclk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  tsc_pen_gate #(.SETTLE(SETTLE_CYC)) u_pen (
    .clk      (clk),
    .rst      (rst),
    .pen_n    (pen_n),
    .hold     (!tsc_cs_n),
    .pen_down (pen_down),
    .armed    (armed)
  );

  // frame 0 carries the Y result, frame 1 the X result
  for (genvar g = 0; g < 2; g++) begin : g_cap
    tsc_capture #(.RES(RES_BITS), .FIRST(g * FRAME + 10), .EW(EW)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .sample   (rise_now),
      .edge_num (edge_nxt),
      .sdi      (tsc_dout),
      .value    (cap[g])
    );
  end

  always_comb begin
    case (frm)
      2'd0:    cur_cmd = CMD_Y;
      2'd1:    cur_cmd = CMD_X;
      default: cur_cmd = CMD_END;
    endcase
    bidx     = 3'd7 - pos[2:0];
    next_bit = (pos < PW'(8)) ? cur_cmd[bidx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tsc_cs_n    <= 1'b1;
      tsc_din     <= 1'b0;
      edge_cnt    <= '0;
      pos         <= '0;
      frm         <= '0;
      coord_valid <= 1'b0;
      coord_x     <= '0;
      coord_y     <= '0;
    end else begin
      coord_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (armed && pen_down) begin
            state    <= ST_RUN;
            tsc_cs_n <= 1'b0;
            tsc_din  <= CMD_Y[7];
            edge_cnt <= '0;
            pos      <= '0;
            frm      <= '0;
          end
        end
        ST_RUN: begin
          if (rise_now) begin
            edge_cnt <= edge_nxt;
            if (pos == PW'(FRAME - 1)) begin
              pos <= '0;
              frm <= frm + 1'b1;
            end else begin
              pos <= pos + 1'b1;
            end
          end else if (fall_now) begin
            if (edge_cnt == EW'(TOTAL)) begin
              tsc_cs_n <= 1'b1;
              tsc_din  <= 1'b0;
              state    <= ST_WAIT;
            end else begin
              tsc_din  <= next_bit;
            end
          end
        end
        default: begin
          if (armed) begin
            if (pen_down) begin
              coord_valid <= 1'b1;
              coord_y     <= cap[0];
              coord_x     <= cap[1];
            end
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assert_dclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    tsc_cs_n |-> !tsc_dclk);

  assert_edges_bound_R5: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= EW'(TOTAL));

  assert_din_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tsc_dclk && $past(tsc_dclk)) |-> $stable(tsc_din));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    coord_valid |=> !coord_valid);

  assert_valid_deselected_R8: assert property (@(posedge clk) disable iff (rst)
    coord_valid |-> tsc_cs_n);

  assert_hold_coords_R9: assert property (@(posedge clk) disable iff (rst)
    ((coord_x != $past(coord_x)) || (coord_y != $past(coord_y))) |-> coord_valid);

  assert_start_armed_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(tsc_cs_n) |-> $past(armed));

endmodule

// File: tb/tsc_scan_master_tb_top.sv
`timescale 1ns/1ps
module tsc_scan_master_tb_top;
  localparam int HALF   = 20;
  localparam int RES    = 12;
  localparam int SETTLE = 8;
  localparam int FRAME  = RES + 3;
  localparam int TOTAL  = 3 * FRAME;

  logic clk = 1'b0, rst = 1'b1, pen_n = 1'b1, dout = 1'b0;
  logic cs_n, dclk, din, valid;
  logic [RES-1:0] x, y;

  always #5 clk = ~clk;

  tsc_scan_master #(.DCLK_HALF(HALF), .RES_BITS(RES), .DIFF_REF(1), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .pen_n(pen_n), .tsc_dout(dout),
    .tsc_cs_n(cs_n), .tsc_dclk(dclk), .tsc_din(din),
    .coord_valid(valid), .coord_x(x), .coord_y(y)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected command bytes for 12-bit, ratiometric reference
  function automatic logic [7:0] exp_cmd(input int i);
    case (i)
      0:       return 8'b1001_0011;
      1:       return 8'b1101_0011;
      default: return 8'b1001_0000;
    endcase
  endfunction

  // ---------------- behavioural converter and reference model ----------------
  logic [RES-1:0] xv = '0, yv = '0, x_sent = '0, y_sent = '0, res_val = '0;
  logic [RES-1:0] exp_x = '0, exp_y = '0;
  logic [7:0] cmd_sr = '0;
  bit   prev_cs = 1, prev_dclk = 0, prev_din = 0, res_wait = 0, exp_valid = 0, model_on = 0;
  int   run_len = 0, edges = 0, pcnt = 0, cmd_idx = 0, res_left = 0, k = -1;
  int   scans = 0, valids = 0;

  always @(negedge clk) begin
    if (model_on) begin
      exp_valid = 0;
      if (k >= 0) begin
        k++;
        if (k == SETTLE + 1) begin
          exp_valid = !pen_n;
          if (exp_valid) begin exp_x = x_sent; exp_y = y_sent; end
          k = -1;
        end
      end
      if (prev_cs && !cs_n) begin
        edges = 0; pcnt = 0; cmd_idx = 0; res_left = 0; res_wait = 0; run_len = 1;
        if (dclk) check(0, "R4 clock high at select", 1, 0);
      end else if (!prev_cs && cs_n) begin
        check(edges == TOTAL, "R5 edges per scan", edges, TOTAL);
        check(cmd_idx == 3, "R6 commands per scan", cmd_idx, 3);
        check(run_len == HALF, "R4 last high phase", run_len, HALF);
        if (dclk) check(0, "R4 clock high after deselect", 1, 0);
        scans++; k = 0; res_left = 0; res_wait = 0;
      end else if (!cs_n) begin
        if (dclk != prev_dclk) begin
          check(run_len == HALF, "R4 phase length", run_len, HALF);
          run_len = 1;
          if (dclk) begin
            edges++;
            if (pcnt == 0) begin
              if (din) begin cmd_sr = 8'h01; pcnt = 1; end
            end else begin
              cmd_sr = {cmd_sr[6:0], din};
              pcnt++;
              if (pcnt == 8) begin
                check(cmd_idx < 3, "R6 extra start bit", cmd_idx, 2);
                check(cmd_sr == exp_cmd(cmd_idx), "R6 command byte", cmd_sr, exp_cmd(cmd_idx));
                check(edges == cmd_idx * FRAME + 8, "R5 command position", edges, cmd_idx * FRAME + 8);
                if (cmd_sr[6:4] == 3'b101) begin res_val = xv; x_sent = xv; end
                else if (cmd_sr[6:4] == 3'b001) begin
                  res_val = yv;
                  if (cmd_idx == 0) y_sent = yv;
                end else res_val = 12'h5A5;
                res_left = RES; res_wait = 1; cmd_idx++; pcnt = 0;
              end
            end
          end else begin
            if (res_wait) res_wait = 0;
            else if (res_left > 0) begin
              res_left--;
              dout = res_val[res_left];
            end
          end
        end else begin
          run_len++;
          if (dclk && (din != prev_din)) check(0, "R6 data moved while clock high", din, prev_din);
        end
      end else if (dclk) begin
        check(0, "R4 clock active while deselected", 1, 0);
      end
      // per-clock comparison against the model
      check(valid === exp_valid, "R8 strobe", valid, exp_valid);
      check(x === exp_x, "R7 x output", x, exp_x);
      check(y === exp_y, "R7 y output", y, exp_y);
      if (valid) valids++;
      prev_cs = cs_n; prev_dclk = dclk; prev_din = din;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_pen(input bit lvl);
    @(posedge clk); #2 pen_n = lvl;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    @(negedge clk);
    for (int i = 0; i < 6000 && !got; i++) begin
      @(negedge clk);
      if (valid) got = 1;
    end
  endtask

  task automatic drain();
    int s;
    @(posedge clk); s = scans;
    set_pen(1);
    for (int i = 0; i < 6000 && cs_n !== 1'b1; i++) @(negedge clk);
    repeat (SETTLE + 10) @(negedge clk);
  endtask

  task automatic run_case(input logic [RES-1:0] xa, input logic [RES-1:0] ya, input string tag);
    bit got;
    xv = xa; yv = ya;
    set_pen(0);
    wait_valid(got);
    check(got, {tag, " strobe"}, got, 1);
    check(x == xa, {tag, " x value"}, x, xa);
    check(y == ya, {tag, " y value"}, y, ya);
    drain();
  endtask

  // ---------------- main sequence ----------------
  initial begin
    bit got;
    int n, s, v;
    repeat (4) @(negedge clk);
    check(cs_n === 1'b1 && dclk === 1'b0 && din === 1'b0, "R1 pins in reset", {cs_n, dclk, din}, 3'b100);
    check(valid === 1'b0 && x === '0 && y === '0, "R1 outputs in reset", valid, 0);
    @(posedge clk); #2 rst = 0; model_on = 1;

    repeat (300) @(negedge clk);
    check(scans == 0 && cs_n === 1'b1, "R2 no scan while pen up", scans, 0);

    // R3 start latency, R7/R8 first result
    xv = 12'hABC; yv = 12'h123;
    set_pen(0);
    n = 0;
    while (cs_n === 1'b1 && n < 100) begin @(negedge clk); n++; end
    check(n == 4, "R3 select latency", n, 4);
    wait_valid(got);
    check(got, "R8 strobe after scan", got, 1);
    check(x == 12'hABC, "R7 x capture", x, 12'hABC);
    check(y == 12'h123, "R7 y capture", y, 12'h123);

    // R9: pen lifted during the trailing scan
    @(posedge clk); s = scans; v = valids;
    #2 pen_n = 1;
    for (int i = 0; i < 6000 && scans <= s; i++) @(negedge clk);
    repeat (SETTLE + 10) @(negedge clk);
    check(scans == s + 1, "R9 trailing scan ran", scans, s + 1);
    check(valids == v, "R9 no strobe after pen-up", valids, v);
    check(x == 12'hABC && y == 12'h123, "R9 outputs held", x, 12'hABC);

    run_case(12'hFFF, 12'h000, "R7 extremes");
    run_case(12'h000, 12'hFFF, "R7 swapped extremes");
    run_case(12'h800, 12'h001, "R7 bit order");
    run_case(12'h555, 12'hAAA, "R7 alternating");

    // R10: bounce during the scan
    @(posedge clk); s = scans;
    xv = 12'h5A5; yv = 12'h3C3;
    #2 pen_n = 0;
    for (int i = 0; i < 100 && cs_n === 1'b1; i++) @(negedge clk);
    repeat (300) @(negedge clk);
    set_pen(1);
    repeat (60) @(posedge clk);
    #2 pen_n = 0;
    check(cs_n === 1'b0, "R10 scan not aborted by bounce", cs_n, 0);
    wait_valid(got);
    check(got, "R10 strobe after bounce", got, 1);
    check(scans == s + 1, "R10 single scan", scans, s + 1);
    check(x == 12'h5A5 && y == 12'h3C3, "R10 values after bounce", x, 12'h5A5);
    drain();

    // R11: held pen repeats scans with fresh values
    xv = 12'h111; yv = 12'h222;
    set_pen(0);
    wait_valid(got);
    check(got && x == 12'h111 && y == 12'h222, "R11 first held scan", x, 12'h111);
    xv = 12'h333; yv = 12'h444;
    wait_valid(got);
    check(got, "R11 second strobe", got, 1);
    check(x == 12'h333 && y == 12'h444, "R11 fresh values", x, 12'h333);
    drain();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule